// File: doc/BRIEF.md
# USB Test Mode Control Register

This block is a one-byte register that firmware writes to place the USB line pins into fixed states for compliance testing. Writes are accepted only at the register's byte address, 0x84. Each written value is checked against two exclusivity rules: the two speed-force bits may not both be set, and at most one of the four line-pattern bits may be set. A legal value that sets at least one mode bit is stored and then locked. After that, the register holds its value against every later write, and only an active-low power-on reset clears it.

The stored value drives two decoded selections for the transceiver. One is a speed-force selection and the other is a line-pattern selection. There is also a flag that is high while a pattern is active. An illegal write is discarded, and the block raises an error pulse for one cycle.

Top module: `usb_tmode_reg`

## Requirements
- R1: While rst_ni is low, rdata_o, speed_sel_o, line_pat_o, test_active_o and err_o are all 0.
- R2: A write (wr_en_i high at a rising clock edge) to address 0x84 with legal data updates rdata_o after that edge. rdata_o shows written bits 7, 4, 3, 2, 1 and 0, and reads bits 6 and 5 as 0.
- R3: A write to 0x84 with both bit 7 (force high speed) and bit 4 (force full speed) set is discarded. err_o is high for exactly the one cycle after that edge.
- R4: A write to 0x84 with more than one of bits 3..0 set is discarded. err_o is high for exactly the one cycle after that edge.
- R5: Writes to any address other than 0x84 change nothing.
- R6: Once any of bits 7, 4, 3..0 is stored, every later write is ignored without raising err_o, until rst_ni is asserted.
- R7: A legal write whose bits 7, 4 and 3..0 are all zero is accepted but does not lock the register. Later writes are still taken.
- R8: speed_sel_o is 2'b10 when bit 7 is stored, 2'b01 when bit 4 is stored, and 2'b00 otherwise.
- R9: line_pat_o is 0 when no pattern bit is stored. It is 1 for bit 0 (SE0/NAK), 2 for bit 1 (J), 3 for bit 2 (K) and 4 for bit 3 (PRBS). test_active_o is high exactly when line_pat_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Stored register value, reserved bits zero |
| speed_sel_o | output | 2 | Speed-force selection |
| line_pat_o | output | 3 | Line-pattern selection |
| test_active_o | output | 1 | A line pattern is latched |
| err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench targets the following corner cases:
- Writes that break each exclusivity rule. A design that checked only one group would latch an illegal pattern pair and drive two pattern selections at once.
- Writes made after the lock. A design whose lock leaked would let a second write change the speed mid-test, or would raise errors on writes that should be silently ignored.
- An all-zero write and a write that sets only reserved bits. Both must leave the register open; a design that locked on any accepted write would wrongly freeze it.
- A write to the neighbouring address. A design that decoded the address too loosely would take it.
- Every pattern encoding. Each one is checked, together with both speed forces and the no-force case.

// File: rtl/usb_tmode_pkg.sv
package usb_tmode_pkg;
  localparam int DW       = 8;
  localparam int HS_BIT   = 7;
  localparam int FS_BIT   = 4;
  localparam int NPAT     = 4;
  localparam logic [DW-1:0] MODE_MASK = (DW'(1) << HS_BIT) | (DW'(1) << FS_BIT) | DW'((1 << NPAT) - 1);

  typedef enum logic [1:0] {SPD_NONE = 2'd0, SPD_FS = 2'd1, SPD_HS = 2'd2} spd_e;
  typedef enum logic [2:0] {PAT_NONE = 3'd0, PAT_SE0 = 3'd1, PAT_J = 3'd2,
                            PAT_K = 3'd3, PAT_PRBS = 3'd4} pat_e;
endpackage

// File: rtl/usb_tmode_check.sv
module usb_tmode_check
  import usb_tmode_pkg::*;
(
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] masked_o,
  output logic          legal_o
);
  logic spd_clash;
  logic pat_multi;

  assign masked_o  = wdata_i & MODE_MASK;
  assign spd_clash = wdata_i[HS_BIT] & wdata_i[FS_BIT];
  assign pat_multi = $countones(wdata_i[NPAT-1:0]) > 1;
  assign legal_o   = !spd_clash && !pat_multi;
endmodule

// File: rtl/usb_tmode_store.sv
module usb_tmode_store
  import usb_tmode_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          locked_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end

  assign q_o      = q;
  assign locked_o = |q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(q) && locked_o) else $error("sticky lost"); // R6
  AST_SPD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q[HS_BIT] && q[FS_BIT])) else $error("speed clash stored"); // R3
  AST_PAT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q[NPAT-1:0])) else $error("pattern clash stored"); // R4
endmodule

// File: rtl/usb_tmode_decode.sv
module usb_tmode_decode
  import usb_tmode_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] q_i,
  output logic [1:0]    speed_sel_o,
  output logic [2:0]    line_pat_o,
  output logic          test_active_o
);
  spd_e spd;
  pat_e pat;

  always_comb begin
    if (q_i[HS_BIT])      spd = SPD_HS;
    else if (q_i[FS_BIT]) spd = SPD_FS;
    else                  spd = SPD_NONE;
  end

  always_comb begin
    unique case (q_i[NPAT-1:0])
      4'b0001: pat = PAT_SE0;
      4'b0010: pat = PAT_J;
      4'b0100: pat = PAT_K;
      4'b1000: pat = PAT_PRBS;
      default: pat = PAT_NONE;
    endcase
  end

  assign speed_sel_o   = spd;
  assign line_pat_o    = pat;
  assign test_active_o = |q_i[NPAT-1:0];

  AST_ACTIVE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_active_o == (line_pat_o != 3'd0)) else $error("active mismatch"); // R9
endmodule

// File: rtl/usb_tmode_reg.sv
module usb_tmode_reg
  import usb_tmode_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] REG_ADDR = AW'('h84)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    speed_sel_o,
  output logic [2:0]    line_pat_o,
  output logic          test_active_o,
  output logic          err_o
);
  logic [DW-1:0] masked;
  logic          legal;
  logic          locked;
  logic          hit;
  logic          load;
  logic          err_q;

  usb_tmode_check u_check (
    .wdata_i  (wdata_i),
    .masked_o (masked),
    .legal_o  (legal)
  );

  assign hit  = wr_en_i && (addr_i == REG_ADDR);
  assign load = hit && !locked && legal;

  usb_tmode_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .d_i      (masked),
    .q_o      (rdata_o),
    .locked_o (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= hit && !locked && !legal;
  end
  assign err_o = err_q;

  usb_tmode_decode u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .q_i           (rdata_o),
    .speed_sel_o   (speed_sel_o),
    .line_pat_o    (line_pat_o),
    .test_active_o (test_active_o)
  );

  AST_BAD_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !locked && wdata_i[HS_BIT] && wdata_i[FS_BIT]) |=> err_o) else $error("no err"); // R3
  AST_LOCK_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> !err_o) else $error("err while locked"); // R6
  AST_ADDR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != REG_ADDR) |=> $stable(rdata_o)) else $error("miss wrote"); // R5
endmodule

// File: tb/usb_tmode_reg_tb_top.sv
module usb_tmode_reg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] speed_sel_o;
  logic [2:0] line_pat_o;
  logic       test_active_o;
  logic       err_o;

  typedef struct packed {
    logic [7:0] rd;
    logic [1:0] spd;
    logic [2:0] pat;
    logic       act;
    logic       err;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] mq = '0;
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  usb_tmode_reg dut_i (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model_out(input logic e);
    exp_t x;
    x.rd  = mq;
    x.spd = mq[7] ? 2'b10 : (mq[4] ? 2'b01 : 2'b00);
    case (mq[3:0])
      4'b0001: x.pat = 3'd1;
      4'b0010: x.pat = 3'd2;
      4'b0100: x.pat = 3'd3;
      4'b1000: x.pat = 3'd4;
      default: x.pat = 3'd0;
    endcase
    x.act = x.pat != 0;
    x.err = e;
    return x;
  endfunction

  task automatic drive(input string tag, input logic we, input logic [7:0] a, input logic [7:0] d);
    logic e;
    @(negedge clk_i);
    wr_en_i = we; addr_i = a; wdata_i = d;
    e = 1'b0;
    if (we && a == 8'h84 && mq == 8'h00) begin
      if ((d[7] && d[4]) || ($countones(d[3:0]) > 1)) e = 1'b1;
      else mq = d & 8'h9F;
    end
    exp_q.push_back(model_out(e));
    tag_q.push_back(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    drive(tag, 1'b1, a, d);
    drive(tag, 1'b0, 8'h00, 8'h00); // err must fall again
  endtask

  task automatic por();
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rst_ni = 1'b0;
    mq = '0;
    #1;
    chk("R1", "rdata", rdata_o, 0);
    chk("R1", "speed", speed_sel_o, 0);
    chk("R1", "pat", line_pat_o, 0);
    chk("R1", "active", test_active_o, 0);
    chk("R1", "err", err_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: compare after each edge that has a pending expectation
  always @(posedge clk_i) begin
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "rdata", rdata_o, e.rd);
      chk(t, "speed", speed_sel_o, e.spd);
      chk(t, "pat", line_pat_o, e.pat);
      chk(t, "active", test_active_o, e.act);
      chk(t, "err", err_o, e.err);
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    por();
    wr("R2_R8_hs", 8'h84, 8'h80);
    wr("R6_locked", 8'h84, 8'h11);
    wr("R6_locked_bad", 8'h84, 8'h90);

    por();
    wr("R3_both_speed", 8'h84, 8'h90);
    wr("R4_two_pat", 8'h84, 8'h06);
    wr("R4_all_pat", 8'h84, 8'h0F);
    wr("R5_other_addr", 8'h85, 8'h10);
    wr("R5_low_addr", 8'h04, 8'h80);
    wr("R7_zero", 8'h84, 8'h00);
    wr("R7_rsvd_only", 8'h84, 8'h60);
    wr("R9_fs_prbs", 8'h84, 8'h18);
    wr("R6_after_lock", 8'h84, 8'h80);

    por();
    wr("R9_fs_k", 8'h84, 8'h14);
    por();
    wr("R9_j", 8'h84, 8'h02);
    por();
    wr("R2_R9_rsvd_se0", 8'h84, 8'hE1);
    por();
    wr("R8_fs_only", 8'h84, 8'h10);

    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule